// File: doc/BRIEF.md
# FIFO Register Window

This block puts a single-clock FIFO behind a small 32-bit word-addressed register bus. A record of three fields is packed into a 48-bit word: a 20-bit field A, a 12-bit field B and a 16-bit field C. The record is spread over two data registers. A control/status register follows the data registers. It reports how full the FIFO is and lets software flush the FIFO. A parameter sets which way records travel.

With `BUS_TO_CORE` = 1, software writes the data registers to build a record in a staging register. The write to the last data register pushes the staged record into the FIFO. The core pops records with its request input and sees the three fields on separate outputs. With `BUS_TO_CORE` = 0, the core pushes records from its field inputs. Software reads data register 0 to pop a record, then reads the remaining fields from the other data register. The core side always sees the FIFO's full flag, empty flag and fill count, and it has its own clear input.

Top module: `fifowin_top`

## Requirements
- R1: The record layout is fixed. Field A is record bits 19:0 and sits in data register 0 bits 19:0. Field B is record bits 31:20 and sits in data register 0 bits 31:20. Field C is record bits 47:32 and sits in data register 1 bits 15:0. Data registers are at word addresses 0 and 1, and the control/status register is at word address 2.
- R2: With BUS_TO_CORE=1, bus writes to the data registers load the staging record. A write to address 1 pushes the staged record, including the data of that write, into the FIFO. A write to address 0 alone does not change the fill count.
- R3: With BUS_TO_CORE=1, a cycle with `core_req_i` high pops the FIFO. The popped fields appear on `fa_o`, `fb_o` and `fc_o` in the next cycle and stay there until the next successful pop.
- R4: With BUS_TO_CORE=0, a cycle with `core_req_i` high pushes {`fc_i`,`fb_i`,`fa_i`}. Bus writes to the data registers have no effect on the FIFO count or on the data read back.
- R5: With BUS_TO_CORE=0, a bus read of address 0 pops the FIFO and returns bits 31:0 of the newly popped record. A read of address 1 returns field C of the last popped record in bits 15:0, with zeros above, and does not pop.
- R6: A read of the control/status register returns the following. Bits 2:0 hold the fill count modulo DEPTH, which is 0 both when the FIFO is empty and when it is full (DEPTH=8). Bit 16 is the full flag and bit 17 is the empty flag. All other bits, including bit 18, read as 0. With BUS_TO_CORE=1, reads of the data registers return 0.
- R7: Writing the control/status register with bit 18 set empties the FIFO. Writing it with bit 18 clear leaves the FIFO unchanged.
- R8: `core_clr_i` held high for one cycle empties the FIFO.
- R9: A push into a full FIFO is dropped. A pop from an empty FIFO leaves the count and the output record unchanged.
- R10: For any access other than a pop read, `bus_ack_o` is high for exactly one cycle, in the second cycle after the request is accepted. For a pop read it is high in the third cycle.
- R11: When a push and a pop reach the FIFO in the same cycle and the FIFO is neither empty nor full, the count stays the same and the head record is popped. When the FIFO is empty, only the push takes effect.
- R12: `core_full_o`, `core_empty_o` and `core_cnt_o` always show the FIFO's full flag, empty flag and count modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_stb_i | input | 1 | Access request, held until acknowledge |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | 2 | Word address |
| bus_wdat_i | input | 32 | Write data |
| bus_rdat_o | output | 32 | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| core_req_i | input | 1 | Core pop (BUS_TO_CORE=1) or push (BUS_TO_CORE=0) request |
| core_clr_i | input | 1 | Core-side FIFO clear |
| core_full_o | output | 1 | FIFO full |
| core_empty_o | output | 1 | FIFO empty |
| core_cnt_o | output | CW | Fill count modulo DEPTH |
| fa_o | output | 20 | Field A of the FIFO output record |
| fb_o | output | 12 | Field B of the FIFO output record |
| fc_o | output | 16 | Field C of the FIFO output record |
| fa_i | input | 20 | Field A to push |
| fb_i | input | 12 | Field B to push |
| fc_i | input | 16 | Field C to push |

## Verification
A push from one side and a pop from the other can reach the FIFO on the same clock edge. In the bus-to-core instance, this is a write to address 1 together with a core pop. In the core-to-bus instance, it is the pop phase of an address 0 read together with a core push. The bench provokes the collision by raising `core_req_i` in the cycle right after the bus request is accepted. It does this both on purpose and at random. A queue model in the bench then predicts the result. The count must stay the same while the old head comes out, except on an empty FIFO, where only the push counts.

// File: rtl/fifowin_pkg.sv
package fifowin_pkg;
  localparam int BUS_W  = 32;
  localparam int FA_W   = 20;
  localparam int FB_W   = 12;
  localparam int FC_W   = 16;
  localparam int FA_LO  = 0;
  localparam int FB_LO  = FA_LO + FA_W;
  localparam int FC_LO  = BUS_W;
  localparam int REC_W  = FC_LO + FC_W;
  localparam int N_REGS = (REC_W + BUS_W - 1) / BUS_W;
  localparam int ADR_W  = $clog2(N_REGS + 1);
  localparam int CSR_FULL_BIT  = 16;
  localparam int CSR_EMPTY_BIT = 17;
  localparam int CSR_CLR_BIT   = 18;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_POP,
    SQ_DLY,
    SQ_ACK
  } seq_state_e;
endpackage

// File: rtl/fifowin_store.sv
module fifowin_store #(
  parameter int W     = 48,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] cnt_o
);
  localparam logic [AW:0]   FULL_N = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   n_q, n_d;
  logic [W-1:0]  dout_q, dout_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push = push_i && (n_q != FULL_N) && !clr_i;
    do_pop  = pop_i && (n_q != '0) && !clr_i;
    wp_d    = wp_q;
    rp_d    = rp_q;
    n_d     = n_q;
    dout_d  = dout_q;
    if (clr_i) begin
      wp_d = '0;
      rp_d = '0;
      n_d  = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST_P) ? '0 : wp_q + 1'b1;
      if (do_pop) begin
        rp_d   = (rp_q == LAST_P) ? '0 : rp_q + 1'b1;
        dout_d = mem[rp_q];
      end
      case ({do_push, do_pop})
        2'b10:   n_d = n_q + 1'b1;
        2'b01:   n_d = n_q - 1'b1;
        default: n_d = n_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      n_q    <= '0;
      dout_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      n_q    <= n_d;
      dout_q <= dout_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  assign dout_o  = dout_q;
  assign full_o  = (n_q == FULL_N);
  assign empty_o = (n_q == '0);
  assign cnt_o   = n_q[AW-1:0];
endmodule

// File: rtl/fifowin_seq.sv
module fifowin_seq
  import fifowin_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic pop_path_i,
  output logic start_o,
  output logic pop_o,
  output logic load_o,
  output logic ack_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE: if (stb_i) st_d = pop_path_i ? SQ_POP : SQ_WAIT;
      SQ_WAIT: st_d = SQ_ACK;
      SQ_POP:  st_d = SQ_DLY;
      SQ_DLY:  st_d = SQ_ACK;
      SQ_ACK:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end

  assign start_o = (st_q == SQ_IDLE) && stb_i;
  assign pop_o   = (st_q == SQ_POP);
  assign load_o  = (st_q == SQ_WAIT) || (st_q == SQ_DLY);
  assign ack_o   = (st_q == SQ_ACK);
endmodule

// File: rtl/fifowin_top.sv
module fifowin_top
  import fifowin_pkg::*;
#(
  parameter bit  BUS_TO_CORE = 1'b1,
  parameter int  DEPTH       = 8,
  localparam int CW          = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_stb_i,
  input  logic              bus_we_i,
  input  logic [ADR_W-1:0]  bus_adr_i,
  input  logic [BUS_W-1:0]  bus_wdat_i,
  output logic [BUS_W-1:0]  bus_rdat_o,
  output logic              bus_ack_o,
  input  logic              core_req_i,
  input  logic              core_clr_i,
  output logic              core_full_o,
  output logic              core_empty_o,
  output logic [CW-1:0]     core_cnt_o,
  output logic [FA_W-1:0]   fa_o,
  output logic [FB_W-1:0]   fb_o,
  output logic [FC_W-1:0]   fc_o,
  input  logic [FA_W-1:0]   fa_i,
  input  logic [FB_W-1:0]   fb_i,
  input  logic [FC_W-1:0]   fc_i
);
  localparam logic [ADR_W-1:0] CSR_ADR  = ADR_W'(N_REGS);
  localparam logic [ADR_W-1:0] LAST_ADR = ADR_W'(N_REGS - 1);

  logic             start, seq_pop, load, ack;
  logic             pop_path, wr_hit;
  logic [ADR_W-1:0] adr_q, adr_d;
  logic             push_q, push_d;
  logic             clr_q, clr_d;
  logic [BUS_W-1:0] rdat_q, rdat_d;
  logic [REC_W-1:0] stage_rec, core_rec, fifo_din, fifo_dout;
  logic             fifo_push, fifo_pop, fifo_clr;
  logic             fifo_full, fifo_empty;
  logic [CW-1:0]    fifo_cnt;
  logic [BUS_W-1:0] dout_word [N_REGS];
  logic [BUS_W-1:0] csr_word;

  // Access sequencing: accept, optional pop + settle phase, one-cycle ack
  assign pop_path = !BUS_TO_CORE && !bus_we_i && (bus_adr_i == '0);

  fifowin_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (bus_stb_i),
    .pop_path_i (pop_path),
    .start_o    (start),
    .pop_o      (seq_pop),
    .load_o     (load),
    .ack_o      (ack)
  );

  assign wr_hit = start && bus_we_i;

  // Staging record and per-register views of the FIFO output
  for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
    localparam int LO = gi * BUS_W;
    localparam int WI = (REC_W - LO < BUS_W) ? (REC_W - LO) : BUS_W;
    logic [WI-1:0] seg_q, seg_d;
    logic          seg_en;

    assign seg_en = wr_hit && BUS_TO_CORE && (bus_adr_i == ADR_W'(gi));

    always_comb begin
      seg_d = seg_q;
      if (seg_en) seg_d = bus_wdat_i[WI-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seg_q <= '0;
      else         seg_q <= seg_d;
    end

    assign stage_rec[LO +: WI] = seg_q;
    assign dout_word[gi]       = BUS_W'(fifo_dout[LO +: WI]);
  end

  assign core_rec = {fc_i, fb_i, fa_i};

  // Control pulses and captured address
  always_comb begin
    adr_d  = start ? bus_adr_i : adr_q;
    push_d = wr_hit && BUS_TO_CORE && (bus_adr_i == LAST_ADR);
    clr_d  = wr_hit && (bus_adr_i == CSR_ADR) && bus_wdat_i[CSR_CLR_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q  <= '0;
      push_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      adr_q  <= adr_d;
      push_q <= push_d;
      clr_q  <= clr_d;
    end
  end

  // FIFO port selection by direction
  assign fifo_din  = BUS_TO_CORE ? stage_rec : core_rec;
  assign fifo_push = BUS_TO_CORE ? push_q : core_req_i;
  assign fifo_pop  = BUS_TO_CORE ? core_req_i : seq_pop;
  assign fifo_clr  = clr_q || core_clr_i;

  fifowin_store #(
    .W     (REC_W),
    .DEPTH (DEPTH)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr),
    .push_i  (fifo_push),
    .pop_i   (fifo_pop),
    .din_i   (fifo_din),
    .dout_o  (fifo_dout),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .cnt_o   (fifo_cnt)
  );

  // Read data
  always_comb begin
    csr_word                = '0;
    csr_word[CW-1:0]        = fifo_cnt;
    csr_word[CSR_FULL_BIT]  = fifo_full;
    csr_word[CSR_EMPTY_BIT] = fifo_empty;
  end

  always_comb begin
    rdat_d = rdat_q;
    if (load) begin
      rdat_d = '0;
      if (adr_q == CSR_ADR) begin
        rdat_d = csr_word;
      end else if (!BUS_TO_CORE) begin
        for (int i = 0; i < N_REGS; i++) begin
          if (adr_q == ADR_W'(i)) rdat_d = dout_word[i];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdat_q <= '0;
    else         rdat_q <= rdat_d;
  end

  assign bus_rdat_o   = rdat_q;
  assign bus_ack_o    = ack;
  assign core_full_o  = fifo_full;
  assign core_empty_o = fifo_empty;
  assign core_cnt_o   = fifo_cnt;
  assign fa_o = BUS_TO_CORE ? fifo_dout[FA_LO +: FA_W] : '0;
  assign fb_o = BUS_TO_CORE ? fifo_dout[FB_LO +: FB_W] : '0;
  assign fc_o = BUS_TO_CORE ? fifo_dout[FC_LO +: FC_W] : '0;
endmodule

// File: rtl/fifowin_chk.sv
module fifowin_chk #(
  parameter int W  = 48,
  parameter int CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] cnt,
  input logic          push,
  input logic          pop,
  input logic          clr,
  input logic [W-1:0]  dout
);
  a_r10_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !ack);

  a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full && empty));

  a_r9_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push && !pop && !clr) |=> (full && $stable(cnt)));

  a_r9_empty_pop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && pop && !push && !clr) |=> (empty && $stable(dout)));

  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (empty && cnt == '0));

  a_r11_both_keep_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && pop && !full && !empty && !clr) |=> ($stable(cnt) && !empty));
endmodule

bind fifowin_top fifowin_chk #(
  .W  (REC_W),
  .CW (CW)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ack    (bus_ack_o),
  .full   (fifo_full),
  .empty  (fifo_empty),
  .cnt    (fifo_cnt),
  .push   (fifo_push),
  .pop    (fifo_pop),
  .clr    (fifo_clr),
  .dout   (fifo_dout)
);

// File: tb/fifowin_top_test.sv
module fifowin_top_test;
  import fifowin_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH);

  logic clk, rst_n;
  logic [1:0] stb, creq, cclr;
  logic we;
  logic [ADR_W-1:0] adr;
  logic [31:0] wdat;
  logic [31:0] rdat0, rdat1;
  logic ack0, ack1, full0, full1, empty0, empty1;
  logic [CW-1:0] cnt0, cnt1;
  logic [19:0] fa0, fa1, fai;
  logic [11:0] fb0, fb1, fbi;
  logic [15:0] fc0, fc1, fci;

  int n_chk = 0, n_err = 0;
  logic [47:0] q0[$], q1[$];
  logic [47:0] last0 = '0, last1 = '0;

  fifowin_top #(.BUS_TO_CORE(1'b1), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_stb_i(stb[0]), .bus_we_i(we),
    .bus_adr_i(adr), .bus_wdat_i(wdat), .bus_rdat_o(rdat0), .bus_ack_o(ack0),
    .core_req_i(creq[0]), .core_clr_i(cclr[0]), .core_full_o(full0),
    .core_empty_o(empty0), .core_cnt_o(cnt0), .fa_o(fa0), .fb_o(fb0), .fc_o(fc0),
    .fa_i(fai), .fb_i(fbi), .fc_i(fci));

  fifowin_top #(.BUS_TO_CORE(1'b0), .DEPTH(DEPTH)) uut_rd (
    .clk_i(clk), .rst_ni(rst_n), .bus_stb_i(stb[1]), .bus_we_i(we),
    .bus_adr_i(adr), .bus_wdat_i(wdat), .bus_rdat_o(rdat1), .bus_ack_o(ack1),
    .core_req_i(creq[1]), .core_clr_i(cclr[1]), .core_full_o(full1),
    .core_empty_o(empty1), .core_cnt_o(cnt1), .fa_o(fa1), .fb_o(fb1), .fc_o(fc1),
    .fa_i(fai), .fb_i(fbi), .fc_i(fci));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] csr_exp(input int n);
    logic [31:0] v = '0;
    v[CW-1:0] = CW'(n % DEPTH);
    v[16] = (n == DEPTH);
    v[17] = (n == 0);
    return v;
  endfunction

  function automatic logic [47:0] rnd_rec();
    return {16'($urandom), $urandom};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // One bus access; starts and ends at a negedge with the sequencer idle
  task automatic acc(input int w, input bit wr, input int a, input logic [31:0] d,
                     input bit pop_at, output logic [31:0] r, output int lat);
    logic got;
    stb[w] = 1'b1; we = wr; adr = ADR_W'(a); wdat = d; lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (pop_at) creq[w] = (lat == 1);
      got = (w == 1) ? ack1 : ack0;
    end while (!got && lat < 10);
    r = (w == 1) ? rdat1 : rdat0;
    stb[w] = 1'b0;
    @(negedge clk);
  endtask

  task automatic st0();
    chk("R12 count", 64'(cnt0), 64'(q0.size() % DEPTH));
    chk("R12 full", 64'(full0), 64'(q0.size() == DEPTH));
    chk("R12 empty", 64'(empty0), 64'(q0.size() == 0));
  endtask

  task automatic st1();
    chk("R12 count", 64'(cnt1), 64'(q1.size() % DEPTH));
    chk("R12 full", 64'(full1), 64'(q1.size() == DEPTH));
    chk("R12 empty", 64'(empty1), 64'(q1.size() == 0));
  endtask

  task automatic csr_chk(input int w);
    logic [31:0] r; int lat;
    acc(w, 1'b0, 2, 32'h0, 1'b0, r, lat);
    chk("R10 csr ack", 64'(lat), 64'd2);
    chk("R6 csr", 64'(r), 64'(csr_exp(w == 1 ? q1.size() : q0.size())));
  endtask

  task automatic b_push(input logic [47:0] rec, input bit pop_at);
    logic [31:0] r; int lat; int n;
    acc(0, 1'b1, 0, rec[31:0], 1'b0, r, lat);
    chk("R10 wr ack", 64'(lat), 64'd2);
    acc(0, 1'b1, 1, {16'h0, rec[47:32]}, pop_at, r, lat);
    chk("R10 wr ack", 64'(lat), 64'd2);
    n = q0.size();
    if (pop_at && n > 0) last0 = q0.pop_front();
    if (n < DEPTH) q0.push_back(rec);
    if (pop_at) chk("R11 head out", 64'({fc0, fb0, fa0}), 64'(last0));
  endtask

  task automatic core_pop0();
    creq[0] = 1'b1;
    @(negedge clk);
    creq[0] = 1'b0;
    if (q0.size() > 0) last0 = q0.pop_front();
    chk("R3 fields", 64'({fc0, fb0, fa0}), 64'(last0));
    chk("R1 field A", 64'(fa0), 64'(last0[19:0]));
  endtask

  task automatic c_push(input logic [47:0] rec);
    fai = rec[19:0]; fbi = rec[31:20]; fci = rec[47:32];
    creq[1] = 1'b1;
    @(negedge clk);
    creq[1] = 1'b0;
    if (q1.size() < DEPTH) q1.push_back(rec);
  endtask

  task automatic c_pop(input bit pop_at, input logic [47:0] rec);
    logic [31:0] r; int lat; int n;
    fai = rec[19:0]; fbi = rec[31:20]; fci = rec[47:32];
    acc(1, 1'b0, 0, 32'h0, pop_at, r, lat);
    n = q1.size();
    if (n > 0) last1 = q1.pop_front();
    if (pop_at && n < DEPTH) q1.push_back(rec);
    chk("R10 pop ack", 64'(lat), 64'd3);
    chk("R5 reg0", 64'(r), 64'(last1[31:0]));
    acc(1, 1'b0, 1, 32'h0, 1'b0, r, lat);
    chk("R10 rd ack", 64'(lat), 64'd2);
    chk("R5 reg1", 64'(r), 64'({16'h0, last1[47:32]}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [31:0] r;
    int lat;
    logic [47:0] rec, ra;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; stb = '0; creq = '0; cclr = '0;
    we = 1'b0; adr = '0; wdat = '0; fai = '0; fbi = '0; fci = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    st0(); st1();
    csr_chk(0); csr_chk(1);
    chk("R3 reset fields", 64'({fc0, fb0, fa0}), 64'd0);

    // ---- bus-to-core instance ----
    acc(0, 1'b1, 0, 32'hDEAD_BEEF, 1'b0, r, lat);
    chk("R2 reg0 no push", 64'(cnt0), 64'd0);
    acc(0, 1'b0, 0, 32'h0, 1'b0, r, lat);
    chk("R6 data reg reads 0", 64'(r), 64'd0);
    rec = 48'h1234_ABCD_E567;
    b_push(rec, 1'b0);
    chk("R2 push", 64'(cnt0), 64'd1);
    csr_chk(0);
    core_pop0();
    chk("R1 field B", 64'(fb0), 64'(12'hABC));
    chk("R1 field C", 64'(fc0), 64'(16'h1234));
    st0();

    // Fill to full, overflow, drain
    for (int i = 0; i < DEPTH; i++) b_push(rnd_rec(), 1'b0);
    st0(); csr_chk(0);
    b_push(48'hFFFF_FFFF_FFFF, 1'b0);
    chk("R9 full push dropped", 64'(q0.size()), 64'(DEPTH));
    st0();
    for (int i = 0; i < DEPTH; i++) core_pop0();
    ra = {fc0, fb0, fa0};
    core_pop0();
    chk("R9 empty pop holds", 64'({fc0, fb0, fa0}), 64'(ra));
    st0();

    // Collisions
    b_push(48'h0000_1111_2222, 1'b1);
    chk("R11 empty collision", 64'(cnt0), 64'd1);
    b_push(48'h0000_3333_4444, 1'b1);
    chk("R11 count kept", 64'(cnt0), 64'd1);
    core_pop0();

    // Clears
    for (int i = 0; i < 3; i++) b_push(rnd_rec(), 1'b0);
    acc(0, 1'b1, 2, 32'h0000_FFFF, 1'b0, r, lat);
    chk("R7 write 0 no clear", 64'(cnt0), 64'd3);
    acc(0, 1'b1, 2, 32'h0004_0000, 1'b0, r, lat);
    q0.delete();
    chk("R7 clear", 64'(cnt0), 64'd0);
    st0(); csr_chk(0);
    b_push(rnd_rec(), 1'b0); b_push(rnd_rec(), 1'b0);
    cclr[0] = 1'b1; @(negedge clk); cclr[0] = 1'b0;
    q0.delete();
    chk("R8 core clear", 64'(empty0), 64'd1);
    st0();

    // Random mix
    for (int i = 0; i < 120; i++) begin
      case ($urandom % 4)
        0, 1: b_push(rnd_rec(), 1'($urandom % 2));
        2: core_pop0();
        default: csr_chk(0);
      endcase
      st0();
    end

    // ---- core-to-bus instance ----
    ra = rnd_rec(); c_push(ra);
    c_push(rnd_rec()); c_push(rnd_rec());
    st1(); csr_chk(1);
    acc(1, 1'b1, 0, 32'h5555_5555, 1'b0, r, lat);
    acc(1, 1'b1, 1, 32'h5555_5555, 1'b0, r, lat);
    chk("R4 bus write ignored", 64'(cnt1), 64'd3);
    acc(1, 1'b0, 1, 32'h0, 1'b0, r, lat);
    chk("R4 reg1 unchanged", 64'(r), 64'd0);
    c_pop(1'b0, '0);
    chk("R5 first record", 64'(last1), 64'(ra));
    st1();
    c_pop(1'b1, rnd_rec());
    chk("R11 pop+push count", 64'(cnt1), 64'd2);
    c_pop(1'b0, '0); c_pop(1'b0, '0);
    st1();
    ra = last1;
    c_pop(1'b0, '0);
    chk("R9 empty pop returns previous", 64'(last1), 64'(ra));
    st1();
    for (int i = 0; i < DEPTH + 2; i++) c_push(rnd_rec());
    chk("R9 full", 64'(full1), 64'd1);
    st1(); csr_chk(1);
    cclr[1] = 1'b1; @(negedge clk); cclr[1] = 1'b0;
    q1.delete();
    chk("R8 core clear", 64'(cnt1), 64'd0);
    acc(1, 1'b1, 2, 32'h0004_0000, 1'b0, r, lat);
    chk("R7 clear empty", 64'(empty1), 64'd1);

    for (int i = 0; i < 100; i++) begin
      case ($urandom % 4)
        0: c_push(rnd_rec());
        1: c_pop(1'($urandom % 2), rnd_rec());
        2: c_push(rnd_rec());
        default: csr_chk(1);
      endcase
      st1();
    end

    summary();
  end
endmodule